// File: doc/BRIEF.md
# USB Full-Speed Device Link State Tracker

This block follows the link of a Full-Speed USB device through its connection life cycle. It watches the VBUS sense input, the pull-up enable, the sampled line condition (SE0, J or any other non-J condition) and a start-of-frame strobe from the protocol engine. From these it keeps a 3-bit link state.

The block raises single-cycle strobes when the link detaches, sees a bus reset, suspends, resumes or loses the host. It drives a suspend indication for the transceiver and gates the receiver-enable request, so the receiver is switched off while the link is suspended.

Three saturating run timers qualify the timed conditions. They count cycles of the 48 MHz clock: SE0 for a bus reset, J idle for suspend, and the gap between frame markers while the link is active. Each timer restarts as soon as its condition breaks. Each timer fires at most once per uninterrupted run.

Top module: `usb_link_state`

## Requirements
- R1: After synchronous reset the link state is 0 (Detached), every event strobe is low and the suspend output is low.
- R2: The state becomes Detached (0) on the edge after VBUS sense or pull-up enable is sampled low. Entry from any other state raises the detach strobe. With both inputs high, Detached moves to Powered (1) on the next edge.
- R3: State codes are 0 Detached, 1 Powered, 2 Powered-Suspended, 3 Active-No-SOF, 4 Active, 5 Suspended and 6 Resuming. No other value appears.
- R4: The line is SE0 when line_se0_i is high. When SE0 is sampled on RESET_CYCLES consecutive edges in any attached state, the state becomes Active-No-SOF (3) on that edge and the bus-reset strobe is raised.
- R5: The line is J when line_se0_i is low and line_j_i is high. When J is sampled on SUSPEND_CYCLES consecutive edges, the state moves on the last of them. Powered moves to Powered-Suspended (2). Active-No-SOF or Active moves to Suspended (5). The suspend strobe is raised.
- R6: A non-J sample moves Powered-Suspended to Powered and Suspended to Resuming, and each such move raises the resume strobe. Resuming moves to Active-No-SOF on the first J sample.
- R7: An SOF strobe moves Active-No-SOF to Active. SOF strobes in the other states leave the state unchanged.
- R8: While Active, the host-lost strobe is raised on the FRAME_CYCLES*LOST_FRAMES-th edge after the last SOF edge. An SOF sampled on that deadline edge restarts the count and no strobe is raised.
- R9: suspend_o is high exactly in states 2 and 5. rx_enable_o equals rx_enable_req_i while not suspended and is low while suspended.
- R10: Any change of line condition restarts the SE0 and J timers. A timer fires only once for a single uninterrupted run.
- R11: Each strobe lasts exactly one cycle per occurrence. Detach, bus reset, suspend and resume never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 48 MHz clock |
| rst_i | input | 1 | Synchronous active-high reset |
| vbus_sense_i | input | 1 | VBUS present |
| pullup_en_i | input | 1 | Interface and pull-up enabled |
| line_se0_i | input | 1 | Line sampled as SE0 (takes priority) |
| line_j_i | input | 1 | Line sampled as J |
| sof_i | input | 1 | One-cycle start-of-frame strobe |
| rx_enable_req_i | input | 1 | Requested receiver enable |
| link_state_o | output | 3 | Encoded link state |
| ev_detach_o | output | 1 | Detach strobe |
| ev_bus_reset_o | output | 1 | Bus reset strobe |
| ev_suspend_o | output | 1 | Suspend strobe |
| ev_resume_o | output | 1 | Resume strobe |
| ev_host_lost_o | output | 1 | Host-lost strobe |
| suspend_o | output | 1 | Link suspended |
| rx_enable_o | output | 1 | Gated receiver enable |

## Verification
Two functions can fall on the same cycle: the host-lost deadline expiring and a fresh SOF strobe arriving. The bench drives an SOF exactly on the edge that is FRAME_CYCLES*LOST_FRAMES edges after the previous one. It expects the state to stay Active with no host-lost strobe on that edge or the next. A separate run with no SOF, which must raise the strobe on the deadline edge, gives the contrast.

// File: rtl/usb_link_pkg.sv
package usb_link_pkg;

    typedef enum logic [2:0] {
        LS_DETACHED     = 3'd0,
        LS_POWERED      = 3'd1,
        LS_POWERED_SUSP = 3'd2,
        LS_ACTIVE_NOSOF = 3'd3,
        LS_ACTIVE       = 3'd4,
        LS_SUSPENDED    = 3'd5,
        LS_RESUMING     = 3'd6
    } link_state_e;

    typedef enum logic [1:0] {
        LINE_SE0  = 2'd0,
        LINE_J    = 2'd1,
        LINE_NONJ = 2'd2
    } line_e;

    typedef struct packed {
        logic host_lost;
        logic resume;
        logic suspend;
        logic bus_reset;
        logic detach;
    } link_events_t;

    localparam int unsigned NUM_TIMERS = 3;
    localparam int unsigned TMR_SE0    = 0;
    localparam int unsigned TMR_IDLE   = 1;
    localparam int unsigned TMR_FRAME  = 2;

    function automatic line_e classify_line(input logic se0, input logic j);
        if (se0)    return LINE_SE0;
        else if (j) return LINE_J;
        else        return LINE_NONJ;
    endfunction

    function automatic logic is_suspended(input link_state_e s);
        return (s == LS_POWERED_SUSP) || (s == LS_SUSPENDED);
    endfunction

endpackage

// File: rtl/usb_link_run_timer.sv
module usb_link_run_timer #(
    parameter int unsigned LIMIT = 144
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    output logic expire_o
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Counts consecutive cycles with run_i high; saturates at LIMIT so the
    // expiry fires once per run.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(LIMIT)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign expire_o = run_i && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/usb_link_fsm.sv
module usb_link_fsm
    import usb_link_pkg::*;
(
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         attached_i,
    input  line_e        line_i,
    input  logic         sof_i,
    input  logic         reset_fire_i,
    input  logic         idle_fire_i,
    input  logic         lost_fire_i,
    output link_state_e  state_o,
    output link_events_t events_o
);
    link_state_e  state_q, state_d;
    link_events_t ev_q, ev_d;

    always_comb begin
        state_d = state_q;
        ev_d    = '0;
        if (!attached_i) begin
            state_d     = LS_DETACHED;
            ev_d.detach = (state_q != LS_DETACHED);
        end else if (reset_fire_i) begin
            state_d        = LS_ACTIVE_NOSOF;
            ev_d.bus_reset = 1'b1;
            ev_d.host_lost = lost_fire_i;
        end else begin
            ev_d.host_lost = lost_fire_i;
            unique case (state_q)
                LS_DETACHED: state_d = LS_POWERED;
                LS_POWERED: begin
                    if (idle_fire_i) begin
                        state_d      = LS_POWERED_SUSP;
                        ev_d.suspend = 1'b1;
                    end
                end
                LS_POWERED_SUSP: begin
                    if (line_i != LINE_J) begin
                        state_d     = LS_POWERED;
                        ev_d.resume = 1'b1;
                    end
                end
                LS_ACTIVE_NOSOF: begin
                    if (idle_fire_i) begin
                        state_d      = LS_SUSPENDED;
                        ev_d.suspend = 1'b1;
                    end else if (sof_i) begin
                        state_d = LS_ACTIVE;
                    end
                end
                LS_ACTIVE: begin
                    if (idle_fire_i) begin
                        state_d      = LS_SUSPENDED;
                        ev_d.suspend = 1'b1;
                    end
                end
                LS_SUSPENDED: begin
                    if (line_i != LINE_J) begin
                        state_d     = LS_RESUMING;
                        ev_d.resume = 1'b1;
                    end
                end
                LS_RESUMING: begin
                    if (line_i == LINE_J) state_d = LS_ACTIVE_NOSOF;
                end
                default: state_d = LS_DETACHED;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= LS_DETACHED;
            ev_q    <= '0;
        end else begin
            state_q <= state_d;
            ev_q    <= ev_d;
        end
    end

    assign state_o  = state_q;
    assign events_o = ev_q;

endmodule

// File: rtl/usb_link_state.sv
module usb_link_state
    import usb_link_pkg::*;
#(
    parameter int unsigned RESET_CYCLES   = 144,
    parameter int unsigned SUSPEND_CYCLES = 144000,
    parameter int unsigned FRAME_CYCLES   = 48000,
    parameter int unsigned LOST_FRAMES    = 4
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       vbus_sense_i,
    input  logic       pullup_en_i,
    input  logic       line_se0_i,
    input  logic       line_j_i,
    input  logic       sof_i,
    input  logic       rx_enable_req_i,
    output logic [2:0] link_state_o,
    output logic       ev_detach_o,
    output logic       ev_bus_reset_o,
    output logic       ev_suspend_o,
    output logic       ev_resume_o,
    output logic       ev_host_lost_o,
    output logic       suspend_o,
    output logic       rx_enable_o
);
    localparam int unsigned LOST_CYCLES = FRAME_CYCLES * LOST_FRAMES;
    localparam int unsigned TMR_LIMIT [NUM_TIMERS] =
        '{RESET_CYCLES, SUSPEND_CYCLES, LOST_CYCLES};

    logic                  attached;
    line_e                 line;
    link_state_e           state;
    link_events_t          events;
    logic [NUM_TIMERS-1:0] tmr_run;
    logic [NUM_TIMERS-1:0] tmr_fire;

    assign attached = vbus_sense_i && pullup_en_i;
    assign line     = classify_line(line_se0_i, line_j_i);

    assign tmr_run[TMR_SE0]   = attached && (line == LINE_SE0);
    assign tmr_run[TMR_IDLE]  = attached && (line == LINE_J);
    assign tmr_run[TMR_FRAME] = attached && (state == LS_ACTIVE) && !sof_i;

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
        usb_link_run_timer #(
            .LIMIT (TMR_LIMIT[g])
        ) u_tmr (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .run_i    (tmr_run[g]),
            .expire_o (tmr_fire[g])
        );
    end

    usb_link_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .attached_i   (attached),
        .line_i       (line),
        .sof_i        (sof_i),
        .reset_fire_i (tmr_fire[TMR_SE0]),
        .idle_fire_i  (tmr_fire[TMR_IDLE]),
        .lost_fire_i  (tmr_fire[TMR_FRAME]),
        .state_o      (state),
        .events_o     (events)
    );

    assign link_state_o   = state;
    assign ev_detach_o    = events.detach;
    assign ev_bus_reset_o = events.bus_reset;
    assign ev_suspend_o   = events.suspend;
    assign ev_resume_o    = events.resume;
    assign ev_host_lost_o = events.host_lost;
    assign suspend_o      = is_suspended(state);
    assign rx_enable_o    = rx_enable_req_i && !suspend_o;

endmodule

// File: rtl/usb_link_state_chk.sv
module usb_link_state_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       vbus_sense_i,
    input logic       pullup_en_i,
    input logic       sof_i,
    input logic [2:0] link_state_o,
    input logic       ev_detach_o,
    input logic       ev_bus_reset_o,
    input logic       ev_suspend_o,
    input logic       ev_resume_o,
    input logic       ev_host_lost_o,
    input logic       suspend_o,
    input logic       rx_enable_o
);
    p_detach_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!vbus_sense_i || !pullup_en_i) |=> (link_state_o == 3'd0));

    p_detach_ev_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        ev_detach_o |-> (link_state_o == 3'd0 && $past(link_state_o) != 3'd0));

    p_range_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        link_state_o <= 3'd6);

    p_reset_dest_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        ev_bus_reset_o |-> (link_state_o == 3'd3));

    p_suspend_ev_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        ev_suspend_o |-> suspend_o);

    p_active_entry_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (link_state_o == 3'd4 && $past(link_state_o) != 3'd4)
            |-> ($past(sof_i) && $past(link_state_o) == 3'd3));

    p_rx_gate_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        suspend_o |-> !rx_enable_o);

    p_lost_pulse_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        ev_host_lost_o |=> !ev_host_lost_o);

    p_reset_pulse_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        ev_bus_reset_o |=> !ev_bus_reset_o);

    p_event_excl_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({ev_detach_o, ev_bus_reset_o, ev_suspend_o, ev_resume_o}));

endmodule

bind usb_link_state usb_link_state_chk u_chk (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .vbus_sense_i   (vbus_sense_i),
    .pullup_en_i    (pullup_en_i),
    .sof_i          (sof_i),
    .link_state_o   (link_state_o),
    .ev_detach_o    (ev_detach_o),
    .ev_bus_reset_o (ev_bus_reset_o),
    .ev_suspend_o   (ev_suspend_o),
    .ev_resume_o    (ev_resume_o),
    .ev_host_lost_o (ev_host_lost_o),
    .suspend_o      (suspend_o),
    .rx_enable_o    (rx_enable_o)
);

// File: tb/sim_usb_link_state.sv
module sim_usb_link_state;
    localparam int RC = 8;
    localparam int SC = 40;
    localparam int FC = 20;
    localparam int LF = 4;
    localparam int LC = FC * LF;

    localparam logic [4:0] E_NONE = 5'b00000;
    localparam logic [4:0] E_DET  = 5'b00001;
    localparam logic [4:0] E_RST  = 5'b00010;
    localparam logic [4:0] E_SUS  = 5'b00100;
    localparam logic [4:0] E_RES  = 5'b01000;
    localparam logic [4:0] E_LOST = 5'b10000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vbus = 1'b0, pull = 1'b0, se0 = 1'b0, jl = 1'b1, sof = 1'b0, rxreq = 1'b1;
    logic [2:0] st;
    logic ev_det, ev_rst, ev_sus, ev_res, ev_lost, sus, rxen;

    always #10 clk = ~clk;

    usb_link_state #(
        .RESET_CYCLES   (RC),
        .SUSPEND_CYCLES (SC),
        .FRAME_CYCLES   (FC),
        .LOST_FRAMES    (LF)
    ) u0 (
        .clk_i           (clk),
        .rst_i           (rst),
        .vbus_sense_i    (vbus),
        .pullup_en_i     (pull),
        .line_se0_i      (se0),
        .line_j_i        (jl),
        .sof_i           (sof),
        .rx_enable_req_i (rxreq),
        .link_state_o    (st),
        .ev_detach_o     (ev_det),
        .ev_bus_reset_o  (ev_rst),
        .ev_suspend_o    (ev_sus),
        .ev_resume_o     (ev_res),
        .ev_host_lost_o  (ev_lost),
        .suspend_o       (sus),
        .rx_enable_o     (rxen)
    );

    typedef struct {
        int         cyc;
        logic [2:0] st;
        logic [4:0] ev;
        logic       sus;
        logic       rxen;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc_n  = 0;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    // Driver side: queue the outputs expected after the coming rising edge.
    task automatic expect_out(input logic [2:0] es, input logic [4:0] ee, input string tag);
        exp_t e;
        e.cyc  = cyc_n + 1;
        e.st   = es;
        e.ev   = ee;
        e.sus  = (es == 3'd2) || (es == 3'd5);
        e.rxen = rxreq && !e.sus;
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // 0 = SE0, 1 = J, 2 = non-J
    task automatic set_line(input int k);
        se0 = (k == 0);
        jl  = (k == 1);
    endtask

    // Monitor: pop and compare in the cycle each item was queued for.
    initial begin
        forever begin
            @(posedge clk);
            cyc_n++;
            #2;
            while (q.size() > 0 && q[0].cyc == cyc_n) begin
                exp_t e;
                logic [4:0] got_ev;
                e = q.pop_front();
                got_ev = {ev_lost, ev_res, ev_sus, ev_rst, ev_det};
                checks++;
                if (st !== e.st || got_ev !== e.ev || sus !== e.sus || rxen !== e.rxen) begin
                    fails++;
                    $display("FAIL %s: state=%0d ev=%b sus=%b rxen=%b expected state=%0d ev=%b sus=%b rxen=%b",
                             e.tag, st, got_ev, sus, rxen, e.st, e.ev, e.sus, e.rxen);
                end
            end
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        expect_out(3'd0, E_NONE, "R1 reset state");
        step();

        vbus = 1'b1; pull = 1'b1;
        expect_out(3'd1, E_NONE, "R2 attach to powered");
        step();

        set_line(0);
        for (int k = 1; k <= RC; k++) begin
            if (k < RC) expect_out(3'd1, E_NONE, "R4 SE0 not yet qualified");
            else        expect_out(3'd3, E_RST, "R4 bus reset");
            step();
        end
        for (int k = 1; k <= 10; k++) begin
            expect_out(3'd3, E_NONE, "R10 R11 no repeat on long SE0");
            step();
        end

        set_line(1);
        repeat (30) step();
        set_line(2);
        expect_out(3'd3, E_NONE, "R10 J run broken");
        step();
        set_line(1);
        for (int k = 1; k <= SC; k++) begin
            if (k == SC - 1) expect_out(3'd3, E_NONE, "R10 J timer restarted");
            if (k == SC)     expect_out(3'd5, E_SUS, "R5 suspend after reset");
            step();
        end
        expect_out(3'd5, E_NONE, "R11 R9 suspend strobe one cycle, rx gated");
        step();

        set_line(2);
        expect_out(3'd6, E_RES, "R6 resume from suspended");
        step();
        set_line(0);
        expect_out(3'd6, E_NONE, "R6 waiting end of resume");
        step();
        step();
        set_line(1);
        expect_out(3'd3, E_NONE, "R6 end of resume");
        step();

        set_line(2);
        sof = 1'b1;
        expect_out(3'd4, E_NONE, "R7 first SOF");
        step();
        sof = 1'b0;
        for (int k = 1; k <= LC + 1; k++) begin
            if (k == LC - 1) expect_out(3'd4, E_NONE, "R8 before deadline");
            if (k == LC)     expect_out(3'd4, E_LOST, "R8 host lost");
            if (k == LC + 1) expect_out(3'd4, E_NONE, "R11 host lost one cycle");
            step();
        end

        sof = 1'b1;
        expect_out(3'd4, E_NONE, "R8 SOF re-arms");
        step();
        sof = 1'b0;
        for (int k = 1; k <= LC - 1; k++) step();
        sof = 1'b1;
        expect_out(3'd4, E_NONE, "R8 SOF on deadline edge");
        step();
        sof = 1'b0;
        expect_out(3'd4, E_NONE, "R8 no late host lost");
        step();

        set_line(1);
        for (int k = 1; k <= SC; k++) begin
            if (k == SC) expect_out(3'd5, E_SUS, "R5 suspend from active");
            step();
        end
        sof = 1'b1;
        expect_out(3'd5, E_NONE, "R7 SOF ignored while suspended");
        step();
        sof = 1'b0;

        vbus = 1'b0;
        expect_out(3'd0, E_DET, "R2 detach on VBUS loss");
        step();
        expect_out(3'd0, E_NONE, "R11 detach one cycle");
        step();

        rxreq = 1'b0;
        vbus = 1'b1;
        for (int k = 1; k <= SC; k++) begin
            if (k == 1)  expect_out(3'd1, E_NONE, "R2 R9 powered, rx request low");
            if (k == SC) expect_out(3'd2, E_SUS, "R5 powered suspend");
            step();
        end
        rxreq = 1'b1;
        expect_out(3'd2, E_NONE, "R9 rx gated in powered suspend");
        step();
        set_line(2);
        expect_out(3'd1, E_RES, "R6 resume to powered");
        step();
        sof = 1'b1;
        expect_out(3'd1, E_NONE, "R7 SOF ignored while powered");
        step();
        sof = 1'b0;
        pull = 1'b0;
        expect_out(3'd0, E_DET, "R2 detach on pull-up off");
        step();
        step();
        step();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule